// File: doc/BRIEF.md
# Three-Port Parallel Interface with Bit Set/Reset

This peripheral sits on a simple synchronous register bus and gives three 8-bit parallel ports. Port A and port B are whole 8-bit ports. Port C is split into an upper and a lower nibble. A command location on the bus sets each port half to input or to output. Each output bit has its own output-enable pin, so the pads outside the block can be tristated.

The same command location takes two kinds of command. When bit 7 is set, the byte redefines both groups. Group A is port A plus the upper nibble of port C. Group B is port B plus the lower nibble of port C. When bit 7 is clear, the byte forces a single port C bit high or low and leaves every other bit alone.

The mode fields of both groups are made available on output pins. A companion block that runs the strobed handshake modes can pick them up there. In the basic mode, an input port passes its pin values through, and an output port drives whatever value was last stored in its latch.

Top module: `ppi3_top`

## Requirements
- R1: While `cs_n` is high, or while `rd_n` is high, `rdata` is zero. While `cs_n` is high, a bus write changes no latch and does not change the command word.
- R2: After a synchronous active-low reset, every port is an input in mode 0. The command word reads back as 0x9B, every output-enable bit is 0, every latch is 0, and both group mode outputs are 0.
- R3: With `cs_n` low, `addr` selects the target: 0 is port A, 1 is port B, 2 is port C and 3 is the command location. A write takes effect at the clock edge where `wr_n` is low. A read is combinational while `rd_n` is low.
- R4: A command byte with bit 7 = 1 defines the groups. Bits 6..5 are the group A mode. Bit 4 is the port A direction. Bit 3 is the direction of port C bits 7..4. Bit 2 is the group B mode. Bit 1 is the port B direction. Bit 0 is the direction of port C bits 3..0. A direction bit of 1 means input. Each output-enable bit is the inverse of the direction bit of its half.
- R5: Writing a group-definition command clears all three port latches to zero at the same edge.
- R6: A command byte with bit 7 = 0 loads bit 0 into port C bit number bits 3..1. It leaves the other port C bits, ports A and B, and the command word unchanged.
- R7: Reading a port returns the live pin value for each bit set as input, and the latch value for each bit set as output.
- R8: A data write to a port stores the byte in that port's latch whatever its direction. The `*_out` pins always show the latch contents.
- R9: Reading the command location returns the last group-definition byte, with bit 7 set. Bit set/reset commands do not change it.
- R10: `grp_a_mode` carries bits 6..5 and `grp_b_mode` carries bit 2 of the current group-definition byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| pa_in | input | 8 | Port A pin values |
| pa_out | output | 8 | Port A latch drive |
| pa_oe | output | 8 | Port A output enable per bit |
| pb_in | input | 8 | Port B pin values |
| pb_out | output | 8 | Port B latch drive |
| pb_oe | output | 8 | Port B output enable per bit |
| pc_in | input | 8 | Port C pin values |
| pc_out | output | 8 | Port C latch drive |
| pc_oe | output | 8 | Port C output enable per bit |
| grp_a_mode | output | 2 | Group A mode field |
| grp_b_mode | output | 1 | Group B mode field |

## Verification
The assertions check on every cycle the following:
- a deselected bus gives a zero read value;
- each port's output enables switch as a whole half;
- a group-definition command zeroes the latches;
- a bit set/reset lands on the addressed bit;
- a latch with no write strobe stays stable;
- a bit set/reset leaves the command word as it was.

Only the bench scenarios can show the rest:
- how reads mix live pins and latches when directions are mixed;
- the exact command field positions;
- the readback of the command word;
- that a write while deselected leaves no trace.

// File: rtl/ppi3_pkg.sv
// Package: shared widths, the bus select encoding and the reset command word.
// Assumes 8-bit ports and an 8-bit command format.
package ppi3_pkg;
    localparam int PORT_W = 8;
    localparam int IDX_W  = $clog2(PORT_W);
    localparam int HALF_W = PORT_W / 2;

    typedef enum logic [1:0] {
        SEL_A   = 2'd0,
        SEL_B   = 2'd1,
        SEL_C   = 2'd2,
        SEL_CMD = 2'd3
    } sel_e;

    // Every direction bit is input and both groups are in mode 0.
    localparam logic [PORT_W-1:0] CTRL_RST = 8'h9B;
endpackage

// File: rtl/ppi3_ctrl.sv
// Command decoder and command-word register.
// Decodes bus writes into per-port write strobes, a latch clear and a bit set/reset strobe.
// Assumes a synchronous bus: a write is taken at the clock edge where cs_n and wr_n are low.
module ppi3_ctrl
    import ppi3_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic [1:0]        addr,
    input  logic [PORT_W-1:0] wdata,
    output logic [PORT_W-1:0] ctrl_word,
    output logic              we_a,
    output logic              we_b,
    output logic              we_c,
    output logic              clr_all,
    output logic              bsr_we,
    output logic [IDX_W-1:0]  bsr_idx,
    output logic              bsr_val
);
    logic              wr_hit;
    sel_e              sel;
    logic [PORT_W-1:0] ctrl_q;

    // Decode the bus write into separate strobes.
    always_comb begin
        wr_hit  = !cs_n && !wr_n;
        sel     = sel_e'(addr);
        we_a    = wr_hit && (sel == SEL_A);
        we_b    = wr_hit && (sel == SEL_B);
        we_c    = wr_hit && (sel == SEL_C);
        clr_all = wr_hit && (sel == SEL_CMD) && wdata[PORT_W-1];
        bsr_we  = wr_hit && (sel == SEL_CMD) && !wdata[PORT_W-1];
        bsr_idx = wdata[IDX_W:1];
        bsr_val = wdata[0];
    end

    // Hold the last group-definition byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= CTRL_RST;
        else if (clr_all)
            ctrl_q <= wdata;
    end

    assign ctrl_word = ctrl_q;

    // R9
    bsr_keeps_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bsr_we |=> $stable(ctrl_q));
endmodule

// File: rtl/ppi3_port.sv
// One parallel port: output latch, per-bit direction and read mux.
// Supports a full write, a clear-all and a single-bit write.
// Assumes a full write and a single-bit write never arrive in the same cycle.
module ppi3_port #(
    parameter int W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [W-1:0]         wdata,
    input  logic                 clr,
    input  logic                 bit_we,
    input  logic [$clog2(W)-1:0] bit_idx,
    input  logic                 bit_val,
    input  logic [W-1:0]         in_mask,
    input  logic [W-1:0]         pin_in,
    output logic [W-1:0]         latch_q,
    output logic [W-1:0]         oe,
    output logic [W-1:0]         rd_val
);
    // Update the output latch.
    always_ff @(posedge clk) begin
        if (!rst_n)
            latch_q <= '0;
        else if (clr)
            latch_q <= '0;
        else if (we)
            latch_q <= wdata;
        else if (bit_we)
            latch_q[bit_idx] <= bit_val;
    end

    // Per-bit read selection and output enable.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign rd_val[i] = in_mask[i] ? pin_in[i] : latch_q[i];
        assign oe[i]     = !in_mask[i];
    end

    // R5
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (latch_q == '0));
    // R6
    bit_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_we && !clr && !we) |=> (latch_q[$past(bit_idx)] == $past(bit_val)));
    // R8
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && !clr && !bit_we) |=> $stable(latch_q));
endmodule

// File: rtl/ppi3_top.sv
// Three-port parallel interface, top level.
// Connects the command decoder to the three port slices.
// Port C takes its direction from two nibble bits and is the only port that takes bit set/reset.
module ppi3_top
    import ppi3_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [1:0]        addr,
    input  logic [PORT_W-1:0] wdata,
    output logic [PORT_W-1:0] rdata,
    input  logic [PORT_W-1:0] pa_in,
    output logic [PORT_W-1:0] pa_out,
    output logic [PORT_W-1:0] pa_oe,
    input  logic [PORT_W-1:0] pb_in,
    output logic [PORT_W-1:0] pb_out,
    output logic [PORT_W-1:0] pb_oe,
    input  logic [PORT_W-1:0] pc_in,
    output logic [PORT_W-1:0] pc_out,
    output logic [PORT_W-1:0] pc_oe,
    output logic [1:0]        grp_a_mode,
    output logic              grp_b_mode
);
    logic [PORT_W-1:0] ctrl_word;
    logic              we_a, we_b, we_c, clr_all, bsr_we, bsr_val;
    logic [IDX_W-1:0]  bsr_idx;
    logic [PORT_W-1:0] rd_a, rd_b, rd_c, mask_a, mask_b, mask_c;

    ppi3_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .addr(addr),
        .wdata(wdata), .ctrl_word(ctrl_word), .we_a(we_a), .we_b(we_b),
        .we_c(we_c), .clr_all(clr_all), .bsr_we(bsr_we), .bsr_idx(bsr_idx),
        .bsr_val(bsr_val)
    );

    // Expand the command-word direction bits into per-bit input masks.
    always_comb begin
        mask_a = {PORT_W{ctrl_word[4]}};
        mask_b = {PORT_W{ctrl_word[1]}};
        mask_c = {{HALF_W{ctrl_word[3]}}, {HALF_W{ctrl_word[0]}}};
    end

    assign grp_a_mode = ctrl_word[6:5];
    assign grp_b_mode = ctrl_word[2];

    ppi3_port #(.W(PORT_W)) u_port_a (
        .clk(clk), .rst_n(rst_n), .we(we_a), .wdata(wdata), .clr(clr_all),
        .bit_we(1'b0), .bit_idx('0), .bit_val(1'b0), .in_mask(mask_a),
        .pin_in(pa_in), .latch_q(pa_out), .oe(pa_oe), .rd_val(rd_a)
    );

    ppi3_port #(.W(PORT_W)) u_port_b (
        .clk(clk), .rst_n(rst_n), .we(we_b), .wdata(wdata), .clr(clr_all),
        .bit_we(1'b0), .bit_idx('0), .bit_val(1'b0), .in_mask(mask_b),
        .pin_in(pb_in), .latch_q(pb_out), .oe(pb_oe), .rd_val(rd_b)
    );

    ppi3_port #(.W(PORT_W)) u_port_c (
        .clk(clk), .rst_n(rst_n), .we(we_c), .wdata(wdata), .clr(clr_all),
        .bit_we(bsr_we), .bit_idx(bsr_idx), .bit_val(bsr_val), .in_mask(mask_c),
        .pin_in(pc_in), .latch_q(pc_out), .oe(pc_oe), .rd_val(rd_c)
    );

    // Select the read data from the addressed location.
    always_comb begin
        rdata = '0;
        if (!cs_n && !rd_n) begin
            case (sel_e'(addr))
                SEL_A:   rdata = rd_a;
                SEL_B:   rdata = rd_b;
                SEL_C:   rdata = rd_c;
                default: rdata = ctrl_word;
            endcase
        end
    end

    // R1
    idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || rd_n) |-> (rdata == '0));
    // R4
    oe_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($countones(pa_oe) == 0) || ($countones(pa_oe) == PORT_W)) &&
        (($countones(pb_oe) == 0) || ($countones(pb_oe) == PORT_W)));
endmodule

// File: tb/ppi3_top_tb.sv
module ppi3_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 24;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0, rdata;
    logic [7:0] pa_in = 8'h5A, pb_in = 8'hC3, pc_in = 8'h96;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
    logic [1:0] grp_a_mode;
    logic       grp_b_mode;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ppi3_top u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe),
        .grp_a_mode(grp_a_mode), .grp_b_mode(grp_b_mode)
    );

    // Vector fields: {read, addr, wdata, expected rdata}.
    // These cover R3, R4, R5, R6, R7 and R9.
    localparam logic [18:0] VEC [NVEC] = '{
        {1'b0, 2'd3, 8'h80, 8'h00}, {1'b0, 2'd0, 8'h12, 8'h00},
        {1'b1, 2'd0, 8'h00, 8'h12}, {1'b0, 2'd1, 8'h34, 8'h00},
        {1'b1, 2'd1, 8'h00, 8'h34}, {1'b0, 2'd2, 8'h56, 8'h00},
        {1'b1, 2'd2, 8'h00, 8'h56}, {1'b1, 2'd3, 8'h00, 8'h80},
        {1'b0, 2'd3, 8'h0F, 8'h00}, {1'b1, 2'd2, 8'h00, 8'hD6},
        {1'b0, 2'd3, 8'h04, 8'h00}, {1'b1, 2'd2, 8'h00, 8'hD2},
        {1'b1, 2'd3, 8'h00, 8'h80}, {1'b0, 2'd3, 8'h99, 8'h00},
        {1'b1, 2'd0, 8'h00, 8'h5A}, {1'b1, 2'd1, 8'h00, 8'h00},
        {1'b1, 2'd2, 8'h00, 8'h96}, {1'b1, 2'd3, 8'h00, 8'h99},
        {1'b0, 2'd1, 8'h77, 8'h00}, {1'b1, 2'd1, 8'h00, 8'h77},
        {1'b0, 2'd3, 8'h8A, 8'h00}, {1'b1, 2'd2, 8'h00, 8'h90},
        {1'b1, 2'd1, 8'h00, 8'hC3}, {1'b1, 2'd0, 8'h00, 8'h00}
    };

    task automatic chk(input string rq, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", rq, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; addr = a; wdata = d;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; addr = a;
        #1 d = rdata;
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2: state right after reset
        bus_read(2'd3, r); chk("R2 cmd word", r, 8'h9B);
        chk("R2 pa_oe", pa_oe, 8'h00);
        chk("R2 pc_oe", pc_oe, 8'h00);
        chk("R2 pb_out", pb_out, 8'h00);
        chk("R10 reset modes", {5'd0, grp_a_mode, grp_b_mode}, 8'h00);

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][18]) begin
                bus_read(VEC[i][17:16], r);
                chk($sformatf("R3/R7 vec %0d", i), r, VEC[i][7:0]);
            end else begin
                bus_write(VEC[i][17:16], VEC[i][15:8]);
            end
        end

        // R4: enables after 0x8A (A out, B in, C upper in, C lower out)
        chk("R4 pa_oe", pa_oe, 8'hFF);
        chk("R4 pb_oe", pb_oe, 8'h00);
        chk("R4 pc_oe", pc_oe, 8'h0F);
        // R8: port B latch still holds 0x00 after the clear; pins show the latch
        chk("R8 pb_out", pb_out, 8'h00);

        // R7: input half follows the pins live
        pc_in = 8'h3C;
        bus_read(2'd2, r); chk("R7 live pins", r, 8'h30);
        // R6: set bit 1 of port C
        bus_write(2'd3, 8'h03);
        chk("R6 pc_out", pc_out, 8'h02);
        bus_read(2'd2, r); chk("R6 read C", r, 8'h32);
        // R8: a write to the input port B still loads its latch
        bus_write(2'd1, 8'hA5);
        chk("R8 pb_out", pb_out, 8'hA5);
        bus_read(2'd1, r); chk("R7 B input read", r, 8'hC3);

        // R1: a write while deselected is ignored
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b0; addr = 2'd0; wdata = 8'hFF;
        @(negedge clk);
        wr_n = 1'b1; addr = 2'd3; wdata = 8'h80;
        chk("R1 pa_out", pa_out, 8'h00);
        rd_n = 1'b0; #1 chk("R1 rdata cs high", rdata, 8'h00);
        rd_n = 1'b1; cs_n = 1'b0; #1 chk("R1 rdata rd high", rdata, 8'h00);
        cs_n = 1'b1;
        bus_read(2'd3, r); chk("R1 cmd unchanged", r, 8'h8A);

        // R10: mode fields on the outputs
        bus_write(2'd3, 8'hE4);
        chk("R10 modes", {5'd0, grp_a_mode, grp_b_mode}, 8'h07);
        bus_read(2'd3, r); chk("R9 cmd readback", r, 8'hE4);

        // R2: reset in the middle of the run
        bus_write(2'd0, 8'h3C);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R2 pa_out after reset", pa_out, 8'h00);
        chk("R2 pa_oe after reset", pa_oe, 8'h00);
        bus_read(2'd3, r); chk("R2 cmd after reset", r, 8'h9B);
        finish_run();
    end
endmodule